// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block is the host side of an SMBus controller that a CPU runs by polling. Software programs a small set of byte-wide registers: the target address with its direction bit, a command byte, a data/count byte, a block-data byte, and a protocol code in the control register. It then sets the start bit. The sequencer walks through the address, command, count and data phases. It drives a byte-level link engine, which handles start/repeated-start, byte send, byte receive with ACK or NACK, and stop. It reports the outcome in write-1-to-clear status flags. Two protocols are supported, byte-data and block, and each can read or write.

Block transfers move one byte at a time. After each byte the sequencer raises a byte-done flag. It then holds the bus until software has reloaded the block-data register (on a write) or read it (on a read) and cleared the flag. On a block read, the final byte is NACKed in two cases: when the byte count announced by the target runs out, or earlier when software has set the last-byte control bit.

The link command interface is a valid/ready stream. A command stays valid with a stable op and byte until the link asserts ready, and ready may drop at any cycle. Only one command is outstanding at a time. The link answers with a single-cycle response pulse. That pulse cannot be back-pressured, because the sequencer issues nothing new until it has arrived.

Top module: `smb_host_seq`

## Requirements
- R1: After reset every register reads 0 and no link command is valid. Register offsets: status 0, control 1, command 2, address 3, data/count 4, block data 5.
- R2: Address register bits 7:1 hold the 7-bit target address and bit 0 gives the direction (0 write, 1 read). The write-phase address byte is {addr,0} and the read-phase address byte is {addr,1}.
- R3: Byte-data write (protocol code 2, direction 0) issues START, SEND {addr,0}, SEND command, SEND data/count, STOP. Afterwards status reads exactly 0x02.
- R4: Byte-data read (code 2, direction 1) issues START, SEND {addr,0}, SEND command, START, SEND {addr,1}, RECV with NACK, STOP. The received byte lands in the data/count register.
- R5: Block write (code 5, direction 0) sends the count from data/count after the command, then the data bytes starting with the preloaded block byte. After every byte except the last it sets byte-done (status bit 7). It issues no command until software clears that flag, with busy still high.
- R6: Block read (code 5, direction 1) receives the count with ACK after the read address. Each data byte is placed in block data with byte-done set and the bus held. A byte is NACKed when it is the last by count, or when control bit 5 is set. STOP follows after byte-done is cleared.
- R7: A block count of 0 or above 32 sets failed (status bit 4). On a read the sequencer then stops the bus. On a write it does so before any bus activity.
- R8: A protocol code other than 2 or 5 (control bits 4:2) sets failed and causes no bus activity.
- R9: A sent byte that is not ACKed sets device error (status bit 2) and forces STOP. Complete (bit 1) is not set and busy (bit 0) clears.
- R10: A link error response sets bus error (status bit 3) and ends the transaction with STOP.
- R11: Writing 1 to a status flag clears it. Writing back a read status value clears every flag that was set.
- R12: Busy reads 1 from the start write (control bit 6) until the STOP response. A start written while busy is ignored.
- R13: Link ops are encoded START 0, STOP 1, SEND 2, RECV_ACK 3, RECV_NACK 4. A valid command holds its op and byte until ready, and the byte is 0 for non-send ops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register offset for read and write |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| lnk_cmd_valid | output | 1 | Link command valid |
| lnk_cmd_ready | input | 1 | Link accepts the command |
| lnk_cmd_op | output | 3 | Link operation code |
| lnk_cmd_byte | output | 8 | Byte to send |
| lnk_rsp_valid | input | 1 | Single-cycle response from the link |
| lnk_rsp_ack | input | 1 | Target ACKed the sent byte |
| lnk_rsp_err | input | 1 | Bus-level error on the operation |
| lnk_rsp_byte | input | 8 | Received byte |

## Verification
The hardest situation to reach is the block read in which software sets the last-byte bit partway through. To get there, the bench writes the control register while byte-done is still high and only then clears the flag. This ordering makes the next byte, not the one by count, carry the NACK. The start-while-busy case is reached the same way: the bench issues a start write inside a block-write byte-done pause and then checks that the bus trace is unchanged. Block counts are swept from 1 to 4 in both directions. Link back-pressure is toggled on and off, and error responses are injected at chosen command indices.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;

  typedef enum logic [2:0] {
    LK_START     = 3'd0,
    LK_STOP      = 3'd1,
    LK_SEND      = 3'd2,
    LK_RECV_ACK  = 3'd3,
    LK_RECV_NACK = 3'd4
  } link_op_e;

  localparam logic [2:0] OFS_STAT = 3'd0;
  localparam logic [2:0] OFS_CTRL = 3'd1;
  localparam logic [2:0] OFS_CMD  = 3'd2;
  localparam logic [2:0] OFS_ADDR = 3'd3;
  localparam logic [2:0] OFS_DAT0 = 3'd4;
  localparam logic [2:0] OFS_BLK  = 3'd5;

  localparam int ST_BUSY = 0;
  localparam int ST_DONE = 1;
  localparam int ST_DERR = 2;
  localparam int ST_BERR = 3;
  localparam int ST_FAIL = 4;
  localparam int ST_BDON = 7;

  localparam int CT_IEN  = 0;
  localparam int CT_LAST = 5;
  localparam int CT_GO   = 6;

  localparam logic [2:0] PROTO_BYTE  = 3'd2;
  localparam logic [2:0] PROTO_BLOCK = 3'd5;

  typedef struct packed {
    logic done;
    logic dev_err;
    logic bus_err;
    logic fail;
    logic byte_done;
  } flag_set_t;

endpackage

// File: rtl/smb_host_regs.sv
module smb_host_regs
  import smb_host_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          busy_i,
  input  flag_set_t     flags_i,
  input  logic          d0_we_i,
  input  logic          blk_we_i,
  input  logic [DW-1:0] rx_byte_i,
  output logic          go_o,
  output logic [2:0]    proto_o,
  output logic          last_o,
  output logic [DW-1:0] cmd_o,
  output logic [DW-1:0] addr_o,
  output logic [DW-1:0] dat0_o,
  output logic [DW-1:0] blk_o,
  output logic          byte_done_o
);

  logic [DW-1:0] cmd_q, addr_q, dat0_q, blk_q;
  logic [2:0]    proto_q;
  logic          ien_q, last_q, go_q;
  logic          done_q, derr_q, berr_q, fail_q, bdon_q;

  logic wr_stat, wr_ctrl, busy_rd;
  assign wr_stat = reg_wr && (reg_addr == AW'(OFS_STAT));
  assign wr_ctrl = reg_wr && (reg_addr == AW'(OFS_CTRL));
  assign busy_rd = busy_i | go_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0; addr_q <= '0; dat0_q <= '0; blk_q <= '0;
      proto_q <= '0; ien_q <= 1'b0; last_q <= 1'b0; go_q <= 1'b0;
      done_q <= 1'b0; derr_q <= 1'b0; berr_q <= 1'b0;
      fail_q <= 1'b0; bdon_q <= 1'b0;
    end else begin
      go_q <= wr_ctrl && reg_wdata[CT_GO] && !busy_rd;
      if (wr_ctrl) begin
        ien_q   <= reg_wdata[CT_IEN];
        proto_q <= reg_wdata[4:2];
        last_q  <= reg_wdata[CT_LAST];
      end else if (go_q) begin
        last_q <= 1'b0;
      end
      if (reg_wr && reg_addr == AW'(OFS_CMD))  cmd_q  <= reg_wdata;
      if (reg_wr && reg_addr == AW'(OFS_ADDR)) addr_q <= reg_wdata;
      if (d0_we_i) dat0_q <= rx_byte_i;
      else if (reg_wr && reg_addr == AW'(OFS_DAT0)) dat0_q <= reg_wdata;
      if (blk_we_i) blk_q <= rx_byte_i;
      else if (reg_wr && reg_addr == AW'(OFS_BLK)) blk_q <= reg_wdata;
      done_q <= flags_i.done      | (done_q & ~(wr_stat & reg_wdata[ST_DONE]));
      derr_q <= flags_i.dev_err   | (derr_q & ~(wr_stat & reg_wdata[ST_DERR]));
      berr_q <= flags_i.bus_err   | (berr_q & ~(wr_stat & reg_wdata[ST_BERR]));
      fail_q <= flags_i.fail      | (fail_q & ~(wr_stat & reg_wdata[ST_FAIL]));
      bdon_q <= flags_i.byte_done | (bdon_q & ~(wr_stat & reg_wdata[ST_BDON]));
    end
  end

  always_comb begin
    case (reg_addr)
      AW'(OFS_STAT): reg_rdata = {bdon_q, 2'b00, fail_q, berr_q, derr_q, done_q, busy_rd};
      AW'(OFS_CTRL): reg_rdata = {1'b0, 1'b0, last_q, proto_q, 1'b0, ien_q};
      AW'(OFS_CMD):  reg_rdata = cmd_q;
      AW'(OFS_ADDR): reg_rdata = addr_q;
      AW'(OFS_DAT0): reg_rdata = dat0_q;
      AW'(OFS_BLK):  reg_rdata = blk_q;
      default:       reg_rdata = '0;
    endcase
  end

  assign go_o        = go_q;
  assign proto_o     = proto_q;
  assign last_o      = last_q;
  assign cmd_o       = cmd_q;
  assign addr_o      = addr_q;
  assign dat0_o      = dat0_q;
  assign blk_o       = blk_q;
  assign byte_done_o = bdon_q;

  // R11: a write-1 with no concurrent set leaves the flag clear
  p_w1c_fail_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat && reg_wdata[ST_FAIL] && !flags_i.fail |=> !fail_q);
  p_w1c_bdone_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat && reg_wdata[ST_BDON] && !flags_i.byte_done |=> !bdon_q);

endmodule

// File: rtl/smb_host_fsm.sv
module smb_host_fsm
  import smb_host_pkg::*;
#(
  parameter int DW        = 8,
  parameter int MAX_BLOCK = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic [2:0]    proto_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] cmd_i,
  input  logic [DW-1:0] dat0_i,
  input  logic [DW-1:0] blk_i,
  input  logic          last_i,
  input  logic          byte_done_i,
  output logic          busy_o,
  output flag_set_t     flags_o,
  output logic          d0_we_o,
  output logic          blk_we_o,
  output logic          lnk_cmd_valid,
  input  logic          lnk_cmd_ready,
  output link_op_e      lnk_cmd_op,
  output logic [DW-1:0] lnk_cmd_byte,
  input  logic          lnk_rsp_valid,
  input  logic          lnk_rsp_ack,
  input  logic          lnk_rsp_err,
  input  logic [DW-1:0] lnk_rsp_byte
);

  localparam int CW = $clog2(MAX_BLOCK + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR, S_CMD, S_RSTART, S_ADDR_R,
    S_CNT_TX, S_TX, S_TX_WAIT, S_CNT_RX, S_RX, S_RX_WAIT, S_STOP
  } seq_state_e;

  seq_state_e    state_q, state_d;
  logic          pend_q, blk_q, blk_d, rd_q, rd_d, ok_q, ok_d, nack_q, nack_d;
  logic [CW-1:0] remain_q, remain_d;
  logic          bus_state, rsp_take, rx_nack;

  assign rx_nack  = !blk_q || last_i || (remain_q == CW'(1));
  assign rsp_take = pend_q && lnk_rsp_valid;

  always_comb begin
    bus_state    = 1'b1;
    lnk_cmd_op   = LK_SEND;
    lnk_cmd_byte = '0;
    case (state_q)
      S_START, S_RSTART: lnk_cmd_op = LK_START;
      S_ADDR:   lnk_cmd_byte = {addr_i[DW-1:1], 1'b0};
      S_ADDR_R: lnk_cmd_byte = {addr_i[DW-1:1], 1'b1};
      S_CMD:    lnk_cmd_byte = cmd_i;
      S_CNT_TX: lnk_cmd_byte = dat0_i;
      S_TX:     lnk_cmd_byte = blk_q ? blk_i : dat0_i;
      S_CNT_RX: lnk_cmd_op = LK_RECV_ACK;
      S_RX:     lnk_cmd_op = rx_nack ? LK_RECV_NACK : LK_RECV_ACK;
      S_STOP:   lnk_cmd_op = LK_STOP;
      default:  bus_state = 1'b0;
    endcase
  end

  assign lnk_cmd_valid = bus_state && !pend_q;
  assign busy_o        = (state_q != S_IDLE);

  always_comb begin
    state_d  = state_q;
    blk_d    = blk_q;
    rd_d     = rd_q;
    ok_d     = ok_q;
    nack_d   = nack_q;
    remain_d = remain_q;
    flags_o  = '0;
    d0_we_o  = 1'b0;
    blk_we_o = 1'b0;
    case (state_q)
      S_IDLE: if (go_i) begin
        blk_d    = (proto_i == PROTO_BLOCK);
        rd_d     = addr_i[0];
        ok_d     = 1'b1;
        nack_d   = 1'b0;
        remain_d = CW'(dat0_i);
        if (proto_i != PROTO_BYTE && proto_i != PROTO_BLOCK)
          flags_o.fail = 1'b1;
        else if (proto_i == PROTO_BLOCK && !addr_i[0] &&
                 (dat0_i == '0 || dat0_i > DW'(MAX_BLOCK)))
          flags_o.fail = 1'b1;
        else
          state_d = S_START;
      end
      S_TX_WAIT: if (!byte_done_i) state_d = S_TX;
      S_RX_WAIT: if (!byte_done_i) state_d = nack_q ? S_STOP : S_RX;
      default: if (rsp_take) begin
        if (lnk_rsp_err) begin
          flags_o.bus_err = 1'b1;
          ok_d    = 1'b0;
          state_d = (state_q == S_STOP) ? S_IDLE : S_STOP;
        end else if (lnk_cmd_op == LK_SEND && !lnk_rsp_ack) begin
          flags_o.dev_err = 1'b1;
          ok_d    = 1'b0;
          state_d = S_STOP;
        end else begin
          case (state_q)
            S_START:  state_d = S_ADDR;
            S_ADDR:   state_d = S_CMD;
            S_CMD:    state_d = rd_q ? S_RSTART : (blk_q ? S_CNT_TX : S_TX);
            S_RSTART: state_d = S_ADDR_R;
            S_ADDR_R: state_d = blk_q ? S_CNT_RX : S_RX;
            S_CNT_TX: state_d = S_TX;
            S_TX: begin
              if (!blk_q || remain_q == CW'(1)) state_d = S_STOP;
              else begin
                remain_d          = remain_q - CW'(1);
                flags_o.byte_done = 1'b1;
                state_d           = S_TX_WAIT;
              end
            end
            S_CNT_RX: begin
              if (lnk_rsp_byte == '0 || lnk_rsp_byte > DW'(MAX_BLOCK)) begin
                flags_o.fail = 1'b1;
                ok_d    = 1'b0;
                state_d = S_STOP;
              end else begin
                remain_d = CW'(lnk_rsp_byte);
                state_d  = S_RX;
              end
            end
            S_RX: begin
              if (!blk_q) begin
                d0_we_o = 1'b1;
                state_d = S_STOP;
              end else begin
                blk_we_o          = 1'b1;
                flags_o.byte_done = 1'b1;
                remain_d          = remain_q - CW'(1);
                nack_d            = rx_nack;
                state_d           = S_RX_WAIT;
              end
            end
            S_STOP: begin
              flags_o.done = ok_q;
              state_d      = S_IDLE;
            end
            default: state_d = S_IDLE;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      pend_q   <= 1'b0;
      blk_q    <= 1'b0;
      rd_q     <= 1'b0;
      ok_q     <= 1'b0;
      nack_q   <= 1'b0;
      remain_q <= '0;
    end else begin
      state_q  <= state_d;
      blk_q    <= blk_d;
      rd_q     <= rd_d;
      ok_q     <= ok_d;
      nack_q   <= nack_d;
      remain_q <= remain_d;
      if (lnk_cmd_valid && lnk_cmd_ready) pend_q <= 1'b1;
      else if (rsp_take)                 pend_q <= 1'b0;
    end
  end

  // R13: an offered command does not change until accepted
  p_cmd_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_cmd_valid && !lnk_cmd_ready |=>
      lnk_cmd_valid && $stable(lnk_cmd_op) && $stable(lnk_cmd_byte));
  // R12: a start reaches the sequencer only when it is idle
  p_go_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> state_q == S_IDLE);
  // R12: busy only drops on a STOP response
  p_busy_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(rsp_take && state_q == S_STOP));
  // R5: entering the write pause means the byte-done flag is up
  p_tx_pause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == S_TX_WAIT && $past(state_q) == S_TX |-> byte_done_i);

endmodule

// File: rtl/smb_host_seq.sv
module smb_host_seq
  import smb_host_pkg::*;
#(
  parameter int MAX_BLOCK = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       lnk_cmd_valid,
  input  logic       lnk_cmd_ready,
  output logic [2:0] lnk_cmd_op,
  output logic [7:0] lnk_cmd_byte,
  input  logic       lnk_rsp_valid,
  input  logic       lnk_rsp_ack,
  input  logic       lnk_rsp_err,
  input  logic [7:0] lnk_rsp_byte
);

  localparam int AW = 3;
  localparam int DW = 8;

  logic          busy, go, last, byte_done, d0_we, blk_we;
  logic [2:0]    proto;
  logic [DW-1:0] cmd_b, addr_b, dat0_b, blk_b;
  flag_set_t     flags;
  link_op_e      op;

  smb_host_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy_i(busy), .flags_i(flags), .d0_we_i(d0_we), .blk_we_i(blk_we),
    .rx_byte_i(lnk_rsp_byte), .go_o(go), .proto_o(proto), .last_o(last),
    .cmd_o(cmd_b), .addr_o(addr_b), .dat0_o(dat0_b), .blk_o(blk_b),
    .byte_done_o(byte_done)
  );

  smb_host_fsm #(.DW(DW), .MAX_BLOCK(MAX_BLOCK)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .go_i(go), .proto_i(proto), .addr_i(addr_b), .cmd_i(cmd_b),
    .dat0_i(dat0_b), .blk_i(blk_b), .last_i(last), .byte_done_i(byte_done),
    .busy_o(busy), .flags_o(flags), .d0_we_o(d0_we), .blk_we_o(blk_we),
    .lnk_cmd_valid(lnk_cmd_valid), .lnk_cmd_ready(lnk_cmd_ready),
    .lnk_cmd_op(op), .lnk_cmd_byte(lnk_cmd_byte),
    .lnk_rsp_valid(lnk_rsp_valid), .lnk_rsp_ack(lnk_rsp_ack),
    .lnk_rsp_err(lnk_rsp_err), .lnk_rsp_byte(lnk_rsp_byte)
  );

  assign lnk_cmd_op = op;

endmodule

// File: tb/test_smb_host_seq.sv
`timescale 1ns/1ps
module test_smb_host_seq;

  localparam logic [2:0] OP_START = 3'd0, OP_STOP = 3'd1, OP_SEND = 3'd2,
                         OP_RACK = 3'd3, OP_RNACK = 3'd4;
  localparam logic [2:0] A_STAT = 3'd0, A_CTRL = 3'd1, A_CMD = 3'd2,
                         A_ADDR = 3'd3, A_DAT0 = 3'd4, A_BLK = 3'd5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       lnk_cmd_valid, lnk_cmd_ready;
  logic [2:0] lnk_cmd_op;
  logic [7:0] lnk_cmd_byte;
  logic       lnk_rsp_valid, lnk_rsp_ack, lnk_rsp_err;
  logic [7:0] lnk_rsp_byte;

  always #2.5 clk = ~clk;

  smb_host_seq i_smb_host_seq (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lnk_cmd_valid(lnk_cmd_valid), .lnk_cmd_ready(lnk_cmd_ready),
    .lnk_cmd_op(lnk_cmd_op), .lnk_cmd_byte(lnk_cmd_byte),
    .lnk_rsp_valid(lnk_rsp_valid), .lnk_rsp_ack(lnk_rsp_ack),
    .lnk_rsp_err(lnk_rsp_err), .lnk_rsp_byte(lnk_rsp_byte)
  );

  int total = 0, bad = 0;
  logic [2:0] got_op [64];
  logic [7:0] got_b  [64];
  logic [2:0] exp_op [64];
  logic [7:0] exp_b  [64];
  logic [7:0] rx_q   [64];
  logic [7:0] rd_buf [64];
  int got_n = 0, exp_n = 0, rx_i = 0, nack_at = -1, err_at = -1, cyc = 0;
  bit bp = 1'b0;
  logic [7:0] s, v;

  // link model: accepts commands, answers one negedge later
  initial begin
    bit rp;
    logic r_ack, r_err;
    logic [7:0] r_b;
    rp = 1'b0; r_ack = 1'b0; r_err = 1'b0; r_b = '0;
    lnk_cmd_ready = 1'b0; lnk_rsp_valid = 1'b0;
    lnk_rsp_ack = 1'b0; lnk_rsp_err = 1'b0; lnk_rsp_byte = '0;
    forever begin
      @(negedge clk);
      cyc++;
      lnk_rsp_valid = 1'b0;
      if (rp) begin
        lnk_rsp_valid = 1'b1; lnk_rsp_ack = r_ack;
        lnk_rsp_err = r_err; lnk_rsp_byte = r_b; rp = 1'b0;
      end
      lnk_cmd_ready = bp ? (cyc % 3 != 0) : 1'b1;
      if (lnk_cmd_valid && lnk_cmd_ready && got_n < 64) begin
        got_op[got_n] = lnk_cmd_op; got_b[got_n] = lnk_cmd_byte;
        r_ack = (got_n != nack_at);
        r_err = (got_n == err_at);
        r_b   = 8'h00;
        if (lnk_cmd_op == OP_RACK || lnk_cmd_op == OP_RNACK) begin
          r_b = rx_q[rx_i]; rx_i++;
        end
        got_n++; rp = 1'b1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic reset_log();
    got_n = 0; exp_n = 0; rx_i = 0; nack_at = -1; err_at = -1;
  endtask

  task automatic push(input logic [2:0] op, input logic [7:0] b);
    exp_op[exp_n] = op; exp_b[exp_n] = b; exp_n++;
  endtask

  task automatic chk_log(input string req);
    int first;
    first = -1;
    for (int i = 0; i < exp_n && i < got_n; i++)
      if (first < 0 && (got_op[i] !== exp_op[i] || got_b[i] !== exp_b[i])) first = i;
    total++;
    if (got_n != exp_n) begin
      bad++;
      $display("FAIL %s: actual=%0d cmds expected=%0d cmds", req, got_n, exp_n);
    end else if (first >= 0) begin
      bad++;
      $display("FAIL %s: cmd %0d actual=%0h/%0h expected=%0h/%0h", req, first,
               got_op[first], got_b[first], exp_op[first], exp_b[first]);
    end
  endtask

  task automatic wait_idle();
    int g;
    g = 0;
    do begin rd(A_STAT, s); g++; end while (s[0] && g < 5000);
  endtask

  task automatic byte_wr(input logic [6:0] ta, input logic [7:0] c, input logic [7:0] d);
    reset_log();
    wr(A_ADDR, {ta, 1'b0}); wr(A_CMD, c); wr(A_DAT0, d);
    wr(A_CTRL, 8'h48);
    wait_idle();
    push(OP_START, 0); push(OP_SEND, {ta, 1'b0}); push(OP_SEND, c);
    push(OP_SEND, d); push(OP_STOP, 0);
  endtask

  task automatic blk_wr(input logic [6:0] ta, input int cnt, input bit poke);
    int n, bdn, g;
    reset_log();
    wr(A_ADDR, {ta, 1'b0}); wr(A_CMD, 8'hB0 + 8'(cnt)); wr(A_DAT0, 8'(cnt));
    wr(A_BLK, 8'h61); wr(A_CTRL, 8'h54);
    n = 1; bdn = 0; g = 0;
    do begin
      rd(A_STAT, s); g++;
      if (s[7]) begin
        bdn++;
        chk("R5 busy during byte pause", {31'd0, s[0]}, 1);
        if (poke && bdn == 1) wr(A_CTRL, 8'h48); // R12 start while busy
        wr(A_BLK, 8'h61 + 8'(n * 13)); n++;
        wr(A_STAT, 8'h80);
      end
    end while ((s[0] || s[7]) && g < 5000);
    chk("R5 byte-done pauses", bdn, cnt - 1);
    chk("R5 final status", {24'd0, s}, 8'h02);
    push(OP_START, 0); push(OP_SEND, {ta, 1'b0}); push(OP_SEND, 8'hB0 + 8'(cnt));
    push(OP_SEND, 8'(cnt));
    for (int i = 0; i < cnt; i++) push(OP_SEND, 8'h61 + 8'(i * 13));
    push(OP_STOP, 0);
    chk_log(poke ? "R12 start ignored while busy" : "R5 block write trace");
    wr(A_STAT, s);
  endtask

  task automatic blk_rd(input logic [6:0] ta, input int cnt, input int last_after);
    int n, nb, g;
    bit bad_cnt;
    reset_log();
    bad_cnt = (cnt == 0 || cnt > 32);
    nb = bad_cnt ? 0 : ((last_after > 0 && last_after + 1 < cnt) ? last_after + 1 : cnt);
    rx_q[0] = 8'(cnt);
    for (int i = 0; i < 40; i++) rx_q[i + 1] = 8'h30 + 8'(i * 7);
    wr(A_ADDR, {ta, 1'b1}); wr(A_CMD, 8'hC3); wr(A_CTRL, 8'h54);
    n = 0; g = 0;
    do begin
      rd(A_STAT, s); g++;
      if (s[7]) begin
        rd(A_BLK, v); rd_buf[n] = v; n++;
        if (n == last_after) wr(A_CTRL, 8'h34);
        wr(A_STAT, 8'h80);
      end
    end while ((s[0] || s[7]) && g < 5000);
    push(OP_START, 0); push(OP_SEND, {ta, 1'b0}); push(OP_SEND, 8'hC3);
    push(OP_START, 0); push(OP_SEND, {ta, 1'b1}); push(OP_RACK, 0);
    for (int i = 0; i < nb; i++) push((i == nb - 1) ? OP_RNACK : OP_RACK, 0);
    push(OP_STOP, 0);
    if (bad_cnt) begin
      chk_log("R7 bad read count trace");
      chk("R7 failed flag", {24'd0, s}, 8'h10);
    end else begin
      chk_log(last_after > 0 ? "R6 last-bit early NACK" : "R6 block read trace");
      chk("R6 bytes delivered", n, nb);
      for (int i = 0; i < nb && i < n; i++)
        chk("R6 block data", {24'd0, rd_buf[i]}, 8'h30 + 8'(i * 7));
      chk("R6 final status", {24'd0, s}, 8'h02);
    end
    wr(A_STAT, s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), s);
      chk("R1 register reset value", {24'd0, s}, 0);
    end
    chk("R1 no command after reset", {31'd0, lnk_cmd_valid}, 0);

    // R2/R3/R13 byte-data write sweep over addresses, with and without back-pressure
    for (int k = 0; k < 8; k++) begin
      logic [6:0] ta;
      ta = 7'h08 + 7'(k * 17);
      bp = k[0];
      byte_wr(ta, 8'h10 + 8'(k), 8'hE0 ^ 8'(k * 29));
      chk_log("R3 byte write trace R2 R13");
      chk("R3 status complete only", {24'd0, s}, 8'h02);
      wr(A_STAT, 8'h02);
      rd(A_STAT, s);
      chk("R11 complete cleared", {24'd0, s}, 0);
    end

    // R4 byte-data read
    for (int k = 0; k < 2; k++) begin
      reset_log(); bp = k[0];
      rx_q[0] = 8'hA5 ^ 8'(k);
      wr(A_ADDR, 8'hA3); wr(A_CMD, 8'h7E); wr(A_CTRL, 8'h48);
      wait_idle();
      push(OP_START, 0); push(OP_SEND, 8'hA2); push(OP_SEND, 8'h7E);
      push(OP_START, 0); push(OP_SEND, 8'hA3); push(OP_RNACK, 0); push(OP_STOP, 0);
      chk_log("R4 byte read trace");
      chk("R4 status", {24'd0, s}, 8'h02);
      rd(A_DAT0, v);
      chk("R4 received byte", {24'd0, v}, 8'hA5 ^ 8'(k));
      wr(A_STAT, s);
    end

    // R5 block write sweep, R6 block read sweep
    for (int c = 1; c <= 4; c++) begin
      bp = c[0];
      blk_wr(7'h2C, c, 1'b0);
      blk_rd(7'h51, c, 0);
    end
    bp = 1'b1;
    blk_wr(7'h33, 3, 1'b1);   // R12
    blk_rd(7'h19, 4, 1);      // R6 last bit after the first byte
    blk_rd(7'h19, 0, 0);      // R7
    blk_rd(7'h19, 40, 0);     // R7
    bp = 1'b0;

    // R7 bad write count: no bus activity
    reset_log();
    wr(A_ADDR, 8'h40); wr(A_DAT0, 8'h00); wr(A_CTRL, 8'h54);
    wait_idle();
    chk("R7 write count zero status", {24'd0, s}, 8'h10);
    chk("R7 write count zero no bus", got_n, 0);
    wr(A_STAT, s);

    // R8 unsupported protocol code
    reset_log();
    wr(A_ADDR, 8'h40); wr(A_DAT0, 8'h05); wr(A_CTRL, 8'h4C);
    wait_idle();
    chk("R8 bad protocol status", {24'd0, s}, 8'h10);
    chk("R8 bad protocol no bus", got_n, 0);
    wr(A_STAT, s);

    // R9 address NACK, then data NACK
    reset_log(); nack_at = 1;
    wr(A_ADDR, 8'h6E); wr(A_CMD, 8'h01); wr(A_DAT0, 8'h02); wr(A_CTRL, 8'h48);
    wait_idle();
    push(OP_START, 0); push(OP_SEND, 8'h6E); push(OP_STOP, 0);
    chk_log("R9 address NACK trace");
    chk("R9 device error status", {24'd0, s}, 8'h04);
    reset_log(); nack_at = 3;
    wr(A_CTRL, 8'h48);
    wait_idle();
    push(OP_START, 0); push(OP_SEND, 8'h6E); push(OP_SEND, 8'h01);
    push(OP_SEND, 8'h02); push(OP_STOP, 0);
    chk_log("R9 data NACK trace");

    // R10 link error on the command byte (device error still pending)
    reset_log(); err_at = 2;
    wr(A_CTRL, 8'h48);
    wait_idle();
    push(OP_START, 0); push(OP_SEND, 8'h6E); push(OP_SEND, 8'h01); push(OP_STOP, 0);
    chk_log("R10 bus error trace");
    chk("R10 bus error plus earlier device error", {24'd0, s}, 8'h0C);
    // R11 write back what was read
    wr(A_STAT, s);
    rd(A_STAT, s);
    chk("R11 write-back clears all", {24'd0, s}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule